// File: doc/BRIEF.md
# Selectable Test Pattern Generator

This block sits between the converter sample path and the serial formatter. When it is idle it passes each incoming sample through unchanged. When a test mode is selected it replaces the sample with a known word, so that a receiver can check its capture and its timing margins. A receiver that sees the expected words has locked correctly.

A 4-bit mode input picks one of twelve options. These are pass-through, three fixed levels, two patterns that alternate between two words, three ways of replaying four user-supplied words, a counting ramp, and two pseudorandom sequences of length 511 and 8,388,607 bits. Every valid input sample produces one output word one clock later. Sequenced patterns advance only on valid samples and restart from their first word whenever the mode changes. A side flag marks the words that the formatter must send without applying its data format conversion.

Top module: `test_pattern_gen`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid`, `out_data` and `out_raw` are 0.
- R2: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_data` holds its last value.
- R3: Mode 0 and the unused codes 12 to 15 copy `in_data` to `out_data` unchanged, with `out_raw` = 0.
- R4: Fixed modes use the effective length L. Mode 1 gives a single 1 at bit L-1. Mode 2 gives L ones. Mode 3 gives zero. All bits at L and above are zero.
- R5: L is `word_len` clamped to the range 8 to 14. Values below 8 act as 8 and values above 14 act as 14.
- R6: Mode 4 alternates between A and ~A within L bits, starting with A. A has ones at the even bit positions. Mode 7 alternates between all-ones (L bits) and zero, starting with all-ones.
- R7: The user words are w0 = `user_words[13:0]` up to w3 = `user_words[55:42]`, each masked to L bits. Mode 8 cycles w0, w1, w2, w3. Mode 9 alternates w0 and w1. Mode 11 repeats w0.
- R8: Mode 10 outputs 0, 1, 2, ... on successive samples and wraps at 2^L.
- R9: Mode 6 is a 511-bit sequence. The bits are b0..b8 = 0x0DF (MSB first) and b(n) = b(n-9) XOR b(n-5). Sample k = b(9+8k)..b(16+8k), with the first of those bits in `out_data[7]`. Bits 13:8 are 0. The first samples are 0x93 and 0x53.
- R10: Mode 5 uses b0..b22 = 0x029B80 (MSB first) and b(n) = b(n-23) XOR b(n-18). Sample k is the inverse of b(23+8k)..b(30+8k), first bit in `out_data[7]`. Bits 13:8 are 0. The first sample is 0x5C.
- R11: The first valid sample after a change of mode starts that mode's sequence (alternation, user cycle, ramp or pseudorandom) from its first word, even if the mode was used before.
- R12: `out_raw` is 1 for modes 5, 6, 8, 9 and 11 and 0 for all others.
- R13: Cycles with `in_valid` low do not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming sample strobe |
| in_data | input | 14 | Converter sample |
| mode | input | 4 | Pattern select |
| word_len | input | 4 | Requested word length in bits |
| user_words | input | 56 | Four user pattern words, w0 in the low bits |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 14 | Pattern or pass-through word |
| out_raw | output | 1 | Word must skip the format conversion |

## Verification
The bench runs the short sequence for more than 511 samples and compares every word with a bit-serial recurrence. A wrong tap, a wrong seed or a wrong bit order shows up within the first word, and a wrong step count breaks the period. Idle gaps inside user and pseudorandom runs catch a design that advances on every clock instead of on valid samples. The bench leaves a sequenced mode and returns to it, with and without idle cycles between, to catch a restart that is missed or tied to the wrong event. Lengths below 8 and above 14 check the clamp, and the ramp crosses 255 to show that it wraps at the masked length and not at the full counter width.

// File: rtl/tpg_pkg.sv
// Shared mode encoding for the test pattern generator.
// Assumes a 4-bit mode code; codes above 11 are treated as pass-through.
package tpg_pkg;

    typedef enum logic [3:0] {
        M_OFF   = 4'd0,
        M_MID   = 4'd1,
        M_PFS   = 4'd2,
        M_NFS   = 4'd3,
        M_CHK   = 4'd4,
        M_PN23  = 4'd5,
        M_PN9   = 4'd6,
        M_ONOFF = 4'd7,
        M_USR4  = 4'd8,
        M_USR2  = 4'd9,
        M_RAMP  = 4'd10,
        M_USR1  = 4'd11
    } tpg_mode_e;

    // Words in these modes must not be re-coded by the downstream formatter.
    function automatic logic skips_format(input logic [3:0] m);
        return (m == M_PN23) || (m == M_PN9) || (m == M_USR4) ||
               (m == M_USR2) || (m == M_USR1);
    endfunction

endpackage

// File: rtl/tpg_prbs.sv
// Pseudorandom word source: a LEN-bit Fibonacci shift register that moves
// STEP bits per accepted sample and presents the STEP new bits, the oldest
// one in the top bit. Assumes STEP <= LEN and TAP < LEN. 'restart' replaces
// the held state with SEED before stepping, so the current sample becomes
// the first word of the sequence.
module tpg_prbs #(
    parameter int             LEN  = 9,
    parameter int             TAP  = 5,
    parameter logic [LEN-1:0] SEED = '0,
    parameter bit             INV  = 1'b0,
    parameter int             STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            restart,
    output logic [STEP-1:0] word
);

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] cur;
    logic [LEN-1:0] nxt;

    // Choose the start state and unroll STEP shifts of the recurrence.
    always_comb begin
        cur = restart ? SEED : state_q;
        nxt = cur;
        for (int i = 0; i < STEP; i++) begin
            nxt = {nxt[LEN-2:0], nxt[LEN-1] ^ nxt[TAP-1]};
        end
    end

    generate
        if (INV) begin : g_inv
            assign word = ~nxt[STEP-1:0];
        end else begin : g_true
            assign word = nxt[STEP-1:0];
        end
    endgenerate

    // Keep the advanced state only when a sample is taken in this mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (adv) begin
            state_q <= nxt;
        end
    end

endmodule

// File: rtl/tpg_word_gen.sv
// Combinational word builder for the fixed, alternating, user and ramp
// modes. Assumes the caller supplies the sequence index and ramp count,
// already restarted on a mode change. The output is limited to the
// effective length, which is word_len clamped into MIN_W..OUT_W.
module tpg_word_gen #(
    parameter int OUT_W = 14,
    parameter int MIN_W = 8,
    parameter int LEN_W = 4
) (
    input  logic [3:0]         mode,
    input  logic [LEN_W-1:0]   word_len,
    input  logic [1:0]         idx,
    input  logic [OUT_W-1:0]   ramp,
    input  logic [4*OUT_W-1:0] user_words,
    output logic [OUT_W-1:0]   word
);
    import tpg_pkg::*;

    localparam int NUM_USR = 4;

    logic [LEN_W-1:0] len_eff;
    logic [OUT_W-1:0] mask;
    logic [OUT_W-1:0] even_ones;
    logic [OUT_W-1:0] usr [NUM_USR];

    // Clamp the requested length and form the low-bit mask.
    always_comb begin
        if (word_len < LEN_W'(MIN_W)) begin
            len_eff = LEN_W'(MIN_W);
        end else if (word_len > LEN_W'(OUT_W)) begin
            len_eff = LEN_W'(OUT_W);
        end else begin
            len_eff = word_len;
        end
        mask = ~({OUT_W{1'b1}} << len_eff);
    end

    generate
        for (genvar b = 0; b < OUT_W; b++) begin : g_even
            assign even_ones[b] = ((b % 2) == 0);
        end
        for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
            assign usr[u] = user_words[u*OUT_W +: OUT_W];
        end
    endgenerate

    // Pick the pattern word for the current mode and position.
    always_comb begin
        case (mode)
            M_MID:   word = mask ^ (mask >> 1);
            M_PFS:   word = mask;
            M_NFS:   word = '0;
            M_CHK:   word = (idx[0] ? ~even_ones : even_ones) & mask;
            M_ONOFF: word = idx[0] ? '0 : mask;
            M_USR4:  word = usr[idx] & mask;
            M_USR2:  word = usr[{1'b0, idx[0]}] & mask;
            M_USR1:  word = usr[0] & mask;
            M_RAMP:  word = ramp & mask;
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/test_pattern_gen.sv
// Test pattern generator top. It registers one output word per valid input
// sample: either the sample itself or a pattern chosen by 'mode'. It tracks
// the mode of the last accepted sample, so that the first sample taken in
// a different mode restarts every sequence. Assumes PN_W <= OUT_W.
module test_pattern_gen #(
    parameter int OUT_W = 14,
    parameter int MIN_W = 8,
    parameter int PN_W  = 8,
    parameter int LEN_W = $clog2(OUT_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OUT_W-1:0]   in_data,
    input  logic [3:0]         mode,
    input  logic [LEN_W-1:0]   word_len,
    input  logic [4*OUT_W-1:0] user_words,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_raw
);
    import tpg_pkg::*;

    localparam int PAD_W = OUT_W - PN_W;

    logic             started_q;
    logic [3:0]       last_mode_q;
    logic [1:0]       idx_q;
    logic [OUT_W-1:0] ramp_q;
    logic             fresh;
    logic [1:0]       idx;
    logic [OUT_W-1:0] ramp;
    logic [OUT_W-1:0] fixed_word;
    logic [PN_W-1:0]  pn9_word;
    logic [PN_W-1:0]  pn23_word;
    logic [OUT_W-1:0] next_word;

    // Detect a mode change against the last accepted sample and restart the positions.
    always_comb begin
        fresh = !started_q || (mode != last_mode_q);
        idx   = fresh ? 2'd0 : idx_q;
        ramp  = fresh ? '0 : ramp_q;
    end

    // Advance the sequence position on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q   <= 1'b0;
            last_mode_q <= 4'd0;
            idx_q       <= 2'd0;
            ramp_q      <= '0;
        end else if (in_valid) begin
            started_q   <= 1'b1;
            last_mode_q <= mode;
            idx_q       <= idx + 2'd1;
            ramp_q      <= ramp + 1'b1;
        end
    end

    tpg_word_gen #(
        .OUT_W (OUT_W),
        .MIN_W (MIN_W),
        .LEN_W (LEN_W)
    ) u_words (
        .mode       (mode),
        .word_len   (word_len),
        .idx        (idx),
        .ramp       (ramp),
        .user_words (user_words),
        .word       (fixed_word)
    );

    tpg_prbs #(
        .LEN  (9),
        .TAP  (5),
        .SEED (9'h0DF),
        .INV  (1'b0),
        .STEP (PN_W)
    ) u_pn9 (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid && (mode == M_PN9)),
        .restart (fresh),
        .word    (pn9_word)
    );

    tpg_prbs #(
        .LEN  (23),
        .TAP  (18),
        .SEED (23'h029B80),
        .INV  (1'b1),
        .STEP (PN_W)
    ) u_pn23 (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid && (mode == M_PN23)),
        .restart (fresh),
        .word    (pn23_word)
    );

    // Select the pattern source, or the live sample for pass-through codes.
    always_comb begin
        case (mode)
            M_PN9:   next_word = {{PAD_W{1'b0}}, pn9_word};
            M_PN23:  next_word = {{PAD_W{1'b0}}, pn23_word};
            M_MID, M_PFS, M_NFS, M_CHK, M_ONOFF,
            M_USR4, M_USR2, M_USR1, M_RAMP:
                     next_word = fixed_word;
            default: next_word = in_data;
        endcase
    end

    // Register the output word, its strobe and its format-bypass flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_raw   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_word;
                out_raw  <= skips_format(mode);
            end
        end
    end

endmodule

// File: rtl/test_pattern_gen_chk.sv
// Port-level properties of the test pattern generator, attached by bind.
// Assumes the default 4-bit mode encoding from tpg_pkg.
module test_pattern_gen_chk #(
    parameter int OUT_W = 14,
    parameter int PN_W  = 8,
    parameter int LEN_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [OUT_W-1:0]   in_data,
    input logic [3:0]         mode,
    input logic [LEN_W-1:0]   word_len,
    input logic               out_valid,
    input logic [OUT_W-1:0]   out_data,
    input logic               out_raw
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd0) |=> (out_data == $past(in_data) && !out_raw));

    // R4
    neg_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd3) |=> (out_data == '0));

    // R12
    raw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 4'd5 || mode == 4'd6)) |=> out_raw);

    // R9
    pn_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 4'd5 || mode == 4'd6)) |=> (out_data[OUT_W-1:PN_W] == '0));

endmodule

bind test_pattern_gen test_pattern_gen_chk #(
    .OUT_W (OUT_W),
    .PN_W  (PN_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .mode      (mode),
    .word_len  (word_len),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_raw   (out_raw)
);

// File: tb/test_pattern_gen_bench.sv
// Scoreboard bench: 'send' predicts each word from the requirements and
// queues it; a negedge monitor compares the design output with the queue.
module test_pattern_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic [3:0]  mode = '0;
    logic [3:0]  word_len = 4'd8;
    logic [55:0] user_words;
    logic        out_valid;
    logic [13:0] out_data;
    logic        out_raw;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    logic [13:0] last_data = '0;

    logic [14:0] exp_q[$];
    string       req_q[$];
    int          bm_last = -1;
    int          bm_k = 0;
    logic [13:0] uw [4];

    bit pn9b  [0:4400];
    bit pn23b [0:500];

    always #2.5 clk = ~clk;

    test_pattern_gen u_test_pattern_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .mode       (mode),
        .word_len   (word_len),
        .user_words (user_words),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_raw    (out_raw)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Predict one output word and present the sample.
    task automatic send(input int m, input int wl, input logic [13:0] d, input string req);
        int L;
        logic [13:0] mask;
        logic [13:0] a;
        logic [13:0] w;
        bit raw;
        @(negedge clk);
        if (m != bm_last) bm_k = 0;
        L = (wl < 8) ? 8 : ((wl > 14) ? 14 : wl);
        mask = 14'((1 << L) - 1);
        a = '0;
        for (int i = 0; i < L; i += 2) a[i] = 1'b1;
        raw = 1'b0;
        w = '0;
        case (m)
            1:  w = 14'(1 << (L - 1));
            2:  w = mask;
            3:  w = '0;
            4:  w = (bm_k % 2 == 0) ? a : (~a & mask);
            5:  begin
                    for (int i = 0; i < 8; i++) w[7-i] = ~pn23b[23 + 8*bm_k + i];
                    raw = 1'b1;
                end
            6:  begin
                    for (int i = 0; i < 8; i++) w[7-i] = pn9b[9 + 8*bm_k + i];
                    raw = 1'b1;
                end
            7:  w = (bm_k % 2 == 0) ? mask : '0;
            8:  begin w = uw[bm_k % 4] & mask; raw = 1'b1; end
            9:  begin w = uw[bm_k % 2] & mask; raw = 1'b1; end
            10: w = 14'(bm_k % (1 << L));
            11: begin w = uw[0] & mask; raw = 1'b1; end
            default: w = d;
        endcase
        bm_k++;
        bm_last = m;
        in_valid = 1'b1;
        mode = 4'(m);
        word_len = 4'(wl);
        in_data = d;
        exp_q.push_back({raw, w});
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data = 14'h2BAD;
        end
    endtask

    // Monitor: compare each output word; during gaps the word must hold.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", {out_raw, out_data}, 15'h0);
                end else begin
                    logic [14:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check({out_raw, out_data} === e, r, "word {raw,data}", {out_raw, out_data}, e);
                end
                last_data = out_data;
                have_last = 1'b1;
            end else if (have_last) begin
                check(out_data === last_data, "R2", "hold in gap", {1'b0, out_data}, {1'b0, last_data});
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        uw[0] = 14'h3A5C; uw[1] = 14'h0F0F; uw[2] = 14'h1234; uw[3] = 14'h3FFE;
        user_words = {uw[3], uw[2], uw[1], uw[0]};
        // Reference bit streams from the R9 and R10 recurrences.
        for (int i = 0; i < 9; i++) pn9b[i] = 1'((9'h0DF >> (8 - i)) & 1);
        for (int n = 9; n <= 4400; n++) pn9b[n] = pn9b[n-9] ^ pn9b[n-5];
        for (int i = 0; i < 23; i++) pn23b[i] = 1'((23'h029B80 >> (22 - i)) & 1);
        for (int n = 23; n <= 500; n++) pn23b[n] = pn23b[n-23] ^ pn23b[n-18];

        // R1: reset holds outputs low even with a valid sample present.
        in_valid = 1'b1;
        in_data = 14'h1111;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0 && out_raw == 1'b0, "R1", "in reset",
              {out_raw, out_data}, 15'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1", "after reset",
              {out_valid, out_data}, 15'h0);
        mon_on = 1'b1;

        // R3 pass-through for mode 0 and unused codes.
        send(0, 8, 14'h1ABC, "R3");
        send(0, 8, 14'h0001, "R3");
        send(13, 8, 14'h3FFF, "R3");
        send(15, 14, 14'h2222, "R3");
        idle(2);
        // R4 fixed words, R5 clamp.
        send(1, 8, 14'h0, "R4");
        send(2, 8, 14'h0, "R4");
        send(3, 8, 14'h3333, "R4");
        send(1, 11, 14'h0, "R4");
        send(1, 14, 14'h0, "R4");
        send(2, 3, 14'h0, "R5");
        send(2, 15, 14'h0, "R5");
        send(1, 0, 14'h0, "R5");
        // R6 alternation, R11 restart after switching away and back.
        for (int i = 0; i < 5; i++) send(4, 10, 14'h0, "R6");
        for (int i = 0; i < 3; i++) send(7, 9, 14'h0, "R6");
        for (int i = 0; i < 3; i++) send(4, 10, 14'h0, "R11");
        // R7 user patterns, R13 gaps inside the cycle.
        send(8, 14, 14'h0, "R7");
        send(8, 14, 14'h0, "R7");
        idle(3);
        for (int i = 0; i < 5; i++) send(8, 14, 14'h0, "R13");
        for (int i = 0; i < 3; i++) send(9, 8, 14'h0, "R7");
        for (int i = 0; i < 2; i++) send(11, 12, 14'h0, "R7");
        // R12 flag cleared again in a non-raw mode.
        send(2, 8, 14'h0, "R12");
        // R8 ramp across the 8-bit wrap.
        for (int i = 0; i < 260; i++) send(10, 8, 14'h0, "R8");
        // R9 short sequence over more than one period, with a gap.
        for (int i = 0; i < 300; i++) send(6, 8, 14'h0, "R9");
        idle(4);
        for (int i = 0; i < 220; i++) send(6, 8, 14'h0, "R9");
        // R11 restart of the short sequence after another mode, then idle.
        send(2, 8, 14'h0, "R11");
        idle(2);
        for (int i = 0; i < 3; i++) send(6, 8, 14'h0, "R11");
        // R10 long sequence, R13 gap, R11 restart.
        for (int i = 0; i < 20; i++) send(5, 8, 14'h0, "R10");
        idle(2);
        for (int i = 0; i < 20; i++) send(5, 8, 14'h0, "R13");
        send(6, 8, 14'h0, "R11");
        for (int i = 0; i < 4; i++) send(5, 8, 14'h0, "R11");
        idle(4);

        check(exp_q.size() == 0, "R2", "queue drained", 15'(exp_q.size()), 15'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule